// File: doc/BRIEF.md
# General-Purpose I/O Port with Edge Capture

This block is a register-mapped I/O port of up to 32 pins. Software programs each pin as an input or an output, drives output levels through an output latch, and reads back the pin levels after a two-flop synchronizer. Interrupts come out on one line. The interrupt condition is fixed when the block is built. It is one of rising edge, falling edge, either edge, or high level.

In the three edge settings, every qualifying transition sets a sticky capture bit for that pin. The bit stays set until software writes a one to that bit. The interrupt line is the OR over all pins of the capture bits that are enabled in the mask. In the high-level setting the capture register is not used and always reads as zero. The interrupt line then follows the synchronized levels of the enabled pins.

The register bus has no back-pressure. An access is a single cycle with the select high. It is always accepted in that same cycle. Read data is combinational in the cycle of the access and is zero when no read is presented. Pads are outside the block: each pin has an output level and an output enable.

Top module: `gpio_edge_port`

## Requirements
- R1: During and right after reset, the direction, mask, capture and output-latch registers are all zero. No pin is enabled as an output and the interrupt line is low.
- R2: A read of word 0 returns the pin levels. A change on a pin shows up in this read two clock edges after the pin is sampled.
- R3: Word 1 holds the direction, where a 1 makes the pin an output. The output enable of each pin equals its direction bit from the cycle after the write. A write to word 0 sets the output latch, which appears on the output-level pins in the next cycle.
- R4: Word 2 holds the interrupt mask, where a 1 enables the pin. It reads back as written.
- R5: With NPINS below 32, register bits at positions NPINS and above read as zero whatever was written.
- R6: In the rising setting (TRIG=0) a 0-to-1 change sets the capture bit. In the falling setting (TRIG=1) a 1-to-0 change sets it. In the both setting (TRIG=2) either change sets it. A capture bit is never set without such a change.
- R7: Word 3 is the capture register. Writing a 1 clears that bit, and writing a 0 leaves it unchanged.
- R8: If an edge is detected in the same cycle that software clears that capture bit, the bit stays set.
- R9: In the edge settings, the interrupt line is high exactly when some pin has both its capture bit and its mask bit set.
- R10: In the high-level setting (TRIG=3), the interrupt line is high exactly when some enabled pin reads high. The capture register reads zero.
- R11: A write to the capture register never sets a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle (always accepted) |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 2 | Word index: 0 data, 1 direction, 2 mask, 3 capture (byte offsets 0x0/0x4/0x8/0xC) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output latch levels |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds all four trigger settings side by side and drives them with the same stimulus. A reference model compares every output of every build on every clock. Rising-only and falling-only pin patterns separate the rising, falling and both settings. A single-bit rise that is timed to meet a capture clear shows whether the edge wins that collision. Alternating single-bit and multi-bit patterns, together with partial clear masks, show whether clears apply to the right bits and leave the others alone. A long stretch of random pin toggles mixed with random register traffic at a reduced pin count checks the interrupt line against the mask in each setting. It also checks that the upper register bits stay zero.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  localparam int unsigned BUS_W = 32;

  localparam logic [1:0] W_DATA = 2'd0;
  localparam logic [1:0] W_DIR  = 2'd1;
  localparam logic [1:0] W_MASK = 2'd2;
  localparam logic [1:0] W_CAP  = 2'd3;

  typedef struct packed {
    logic data;
    logic dir;
    logic mask;
    logic cap;
  } wr_strobe_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_cap.sv
module gpio_edge_cap
  import gpio_port_pkg::*;
#(
  parameter int    W    = 32,
  parameter trig_e TRIG = TRIG_RISE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] clr,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] cap
);
  localparam bit RISE_EN = (TRIG == TRIG_RISE) || (TRIG == TRIG_BOTH);
  localparam bit FALL_EN = (TRIG == TRIG_FALL) || (TRIG == TRIG_BOTH);
  localparam bit CAP_EN  = (TRIG != TRIG_LEVEL);

  logic [W-1:0] prev_q;
  logic [W-1:0] rise_v, fall_v;
  logic [W-1:0] cap_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise_v   = lvl & ~prev_q;
  assign fall_v   = ~lvl & prev_q;
  assign edge_hit = (RISE_EN ? rise_v : '0) | (FALL_EN ? fall_v : '0);

  // a clear loses against an edge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_r <= '0;
    else        cap_r <= (cap_r & ~clr) | edge_hit;
  end

  generate
    if (CAP_EN) begin : g_cap
      assign cap = cap_r;
    end else begin : g_nocap
      assign cap = '0;
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [1:0]       word,
  input  logic [BUS_W-1:0] wdata,
  input  logic [W-1:0]     lvl,
  input  logic [W-1:0]     cap,
  output logic [W-1:0]     out_q,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     mask_q,
  output logic [W-1:0]     cap_clr,
  output logic [BUS_W-1:0] rdata
);
  wr_strobe_t   stb;
  logic [W-1:0] wbits;
  logic [W-1:0] rsel;
  logic         rd_en;

  assign wbits    = wdata[W-1:0];
  assign stb.data = sel && wr && (word == W_DATA);
  assign stb.dir  = sel && wr && (word == W_DIR);
  assign stb.mask = sel && wr && (word == W_MASK);
  assign stb.cap  = sel && wr && (word == W_CAP);
  assign cap_clr  = stb.cap ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      if (stb.data) out_q  <= wbits;
      if (stb.dir)  dir_q  <= wbits;
      if (stb.mask) mask_q <= wbits;
    end
  end

  assign rd_en = sel && !wr;

  always_comb begin
    unique case (word)
      W_DATA:  rsel = lvl;
      W_DIR:   rsel = dir_q;
      W_MASK:  rsel = mask_q;
      default: rsel = cap;
    endcase
  end

  assign rdata = rd_en ? BUS_W'(rsel) : '0;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int    NPINS       = 32,
  parameter trig_e TRIG        = TRIG_RISE,
  parameter int    SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_word,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam bit LEVEL_MODE = (TRIG == TRIG_LEVEL);

  logic [NPINS-1:0] lvl_sync;
  logic [NPINS-1:0] edge_hit;
  logic [NPINS-1:0] cap_q;
  logic [NPINS-1:0] cap_clr;
  logic [NPINS-1:0] out_q, dir_q, mask_q;
  logic [NPINS-1:0] irq_src;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_sync)
  );

  gpio_edge_cap #(.W(NPINS), .TRIG(TRIG)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .clr(cap_clr),
    .edge_hit(edge_hit), .cap(cap_q)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .word(bus_word),
    .wdata(bus_wdata), .lvl(lvl_sync), .cap(cap_q),
    .out_q(out_q), .dir_q(dir_q), .mask_q(mask_q),
    .cap_clr(cap_clr), .rdata(bus_rdata)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq_src = LEVEL_MODE ? lvl_sync : cap_q;
  assign irq     = |(irq_src & mask_q);
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_port_pkg::*;
#(
  parameter int    NPINS = 32,
  parameter trig_e TRIG  = TRIG_RISE
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_word,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic [NPINS-1:0] lvl_sync,
  input logic [NPINS-1:0] edge_hit,
  input logic [NPINS-1:0] cap_q,
  input logic [NPINS-1:0] mask_q
);
  logic cap_wr;
  assign cap_wr = bus_sel && bus_wr && (bus_word == W_CAP);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (pin_oe == '0 && !irq && cap_q == '0)
        else $error("R1 outputs active during reset");
    end
  end

  p_idle_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata == '0);

  p_oe_follows_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_word == W_DIR) |=> pin_oe == $past(bus_wdata[NPINS-1:0]));

  generate
    if (NPINS < BUS_W) begin : g_upper
      p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:NPINS] == '0);
    end

    if (TRIG != TRIG_LEVEL) begin : g_edge
      p_cap_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cap_q & ~$past(cap_q) & ~$past(edge_hit)) == '0);

      p_cap_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_wr |=> (cap_q & $past(cap_q)) == $past(cap_q));

      p_edge_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_wr |=> ($past(edge_hit & bus_wdata[NPINS-1:0]) & ~cap_q) == '0);

      p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cap_q & mask_q) != '0);
    end else begin : g_level
      p_level_nocap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q == '0);

      p_level_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (lvl_sync & mask_q) != '0);

      p_level_noedge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit == '0);
    end
  endgenerate
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NPINS(NPINS), .TRIG(TRIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_oe(pin_oe), .irq(irq), .lvl_sync(lvl_sync), .edge_hit(edge_hit),
  .cap_q(cap_q), .mask_q(mask_q)
);

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;
  import gpio_port_pkg::*;

  localparam int NP = 20;
  localparam logic [31:0] PMASK = 32'((64'd1 << NP) - 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          sel = 1'b0, wr = 1'b0;
  logic [1:0]    word = 2'd0;
  logic [31:0]   wdata = '0;
  logic [NP-1:0] pins = '0;

  logic [3:0][31:0]   rd;
  logic [3:0]         irq_v;
  logic [3:0][NP-1:0] po, poe;

  generate
    for (genvar m = 0; m < 4; m++) begin : g_mode
      gpio_edge_port #(.NPINS(NP), .TRIG(trig_e'(m))) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_word(word),
        .bus_wdata(wdata), .bus_rdata(rd[m]), .pin_in(pins),
        .pin_out(po[m]), .pin_oe(poe[m]), .irq(irq_v[m])
      );
    end
  endgenerate

  int n_chk = 0, n_fail = 0;

  // behavioural reference
  logic [31:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
  logic [31:0] m_out = '0, m_dir = '0, m_mask = '0;
  logic [3:0][31:0] m_cap = '0;

  always @(posedge clk) begin : model
    logic [31:0] rise, fall, clr;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0;
      m_out = '0; m_dir = '0; m_mask = '0; m_cap = '0;
    end else begin
      rise = m_s2 & ~m_prev;
      fall = ~m_s2 & m_prev;
      clr  = '0;
      if (sel && wr) begin
        case (word)
          2'd0: m_out  = wdata & PMASK;
          2'd1: m_dir  = wdata & PMASK;
          2'd2: m_mask = wdata & PMASK;
          default: clr = wdata;
        endcase
      end
      m_cap[0] = ((m_cap[0] & ~clr) | rise) & PMASK;
      m_cap[1] = ((m_cap[1] & ~clr) | fall) & PMASK;
      m_cap[2] = ((m_cap[2] & ~clr) | rise | fall) & PMASK;
      m_cap[3] = '0;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = 32'(pins);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input int m);
    if (!(sel && !wr)) return '0;
    case (word)
      2'd0: return m_s2;
      2'd1: return m_dir;
      2'd2: return m_mask;
      default: return m_cap[m];
    endcase
  endfunction

  function automatic string rd_tag();
    case (word)
      2'd0: return "R2 data read";
      2'd1: return "R3 direction read";
      2'd2: return "R4 mask read";
      default: return "R7 capture read";
    endcase
  endfunction

  always @(negedge clk) begin
    for (int m = 0; m < 4; m++) begin
      logic [31:0] e;
      logic ei;
      e  = exp_rd(m);
      ei = (m == 3) ? |(m_s2 & m_mask) : |(m_cap[m] & m_mask);
      chk(rd[m] == e, rd_tag(), rd[m], e);
      chk(irq_v[m] == ei, (m == 3) ? "R10 level irq" : "R9 edge irq", 32'(irq_v[m]), 32'(ei));
      chk(32'(po[m]) == m_out, "R3 output latch", 32'(po[m]), m_out);
      chk(32'(poe[m]) == m_dir, "R3 output enable", 32'(poe[m]), m_dir);
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic bus_write(input logic [1:0] w, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; word = w; wdata = d;
    cyc();
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] w, input int m, input logic [31:0] exp, input string tag);
    sel = 1'b1; wr = 1'b0; word = w;
    @(negedge clk);
    chk(rd[m] == exp, tag, rd[m], exp);
    cyc();
    sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    peek(2'd1, 0, 32'h0, "R1 direction after reset");
    peek(2'd3, 2, 32'h0, "R1 capture after reset");

    bus_write(2'd0, 32'hFFFA_5A5A);
    bus_write(2'd1, 32'h000F_00F0);
    peek(2'd1, 1, 32'h000F_00F0, "R3 direction readback");
    bus_write(2'd2, 32'hFFFF_FFFF);
    peek(2'd2, 0, 32'h000F_FFFF, "R5 mask upper bits zero");
    peek(2'd2, 3, 32'h000F_FFFF, "R4 mask readback");
    bus_write(2'd3, 32'hFFFF_FFFF);
    peek(2'd3, 0, 32'h0, "R11 capture write does not set");

    pins = 20'h5A5A5;
    repeat (4) cyc();
    peek(2'd0, 0, 32'h0005_A5A5, "R2 synchronized levels");
    peek(2'd3, 0, 32'h0005_A5A5, "R6 rising captured");
    peek(2'd3, 1, 32'h0, "R6 falling ignores rise");
    peek(2'd3, 2, 32'h0005_A5A5, "R6 both captures rise");
    peek(2'd3, 3, 32'h0, "R10 level capture zero");
    bus_write(2'd3, 32'h0000_0005);
    peek(2'd3, 0, 32'h0005_A5A0, "R7 partial clear");

    pins = '0;
    repeat (4) cyc();
    peek(2'd3, 1, 32'h0005_A5A5, "R6 falling captured");
    bus_write(2'd2, 32'h0000_0001);
    @(negedge clk);
    chk(irq_v[1] == 1'b1, "R9 irq from masked capture", 32'(irq_v[1]), 32'h1);
    chk(irq_v[3] == 1'b0, "R10 irq low with pin low", 32'(irq_v[3]), 32'h0);
    cyc();

    bus_write(2'd3, 32'hFFFF_FFFF);
    pins[3] = 1'b1;
    cyc();
    cyc();
    bus_write(2'd3, 32'h0000_0008);
    peek(2'd3, 0, 32'h0000_0008, "R8 edge wins over clear");
    peek(2'd3, 2, 32'h0000_0008, "R8 edge wins over clear (both)");

    pins[0] = 1'b1;
    repeat (3) cyc();
    @(negedge clk);
    chk(irq_v[3] == 1'b1, "R10 level irq high", 32'(irq_v[3]), 32'h1);
    cyc();

    for (int i = 0; i < 3000; i++) begin
      pins = NP'($urandom);
      if (($urandom % 4) == 0) begin
        sel = 1'b1; wr = 1'($urandom); word = 2'($urandom); wdata = $urandom;
      end else begin
        sel = 1'b0; wr = 1'b0;
      end
      cyc();
    end
    sel = 1'b0; wr = 1'b0;
    cyc();

    finish_run();
  end
endmodule